// File: doc/BRIEF.md
# Floating-Point Issue Interlock Scoreboard

This block decides, cycle by cycle, whether the next instruction of an in-order scalar floating-point pipeline may issue. Each instruction arrives as a descriptor on the input side: an operation class, a precision flag, a destination register field and up to three source register fields. For every single-precision register the block keeps a countdown of how many cycles remain until a pending result can be delivered. It compares that countdown with the pipeline cycle in which each source operand is consumed. Issue is held while any operand would arrive late, and also while an earlier multi-cycle instruction still occupies the issue slot.

Multiply-accumulate instructions read the accumulator later than their other operands. When a multiply-accumulate takes its accumulator from the instruction issued just before it, and that instruction is a plain multiply or a multiply-accumulate of the same precision, a dedicated forwarding path lets it issue with no wait. The block also reports how long the current descriptor has been held and the absolute cycle in which its result will exist. Arithmetic, rounding and exceptions are not modelled.

The upstream stage holds a descriptor with `in_valid` until it sees `in_ready` high. The instruction issues at the rising edge where both are high. The issuing instruction's own pipeline cycle 1 is the cycle in which it issues.

Top module: `fp_issue_sb`

## Requirements
- R1: After reset, `in_ready` is high, `stall_cnt` is 0 and no register has a pending result.
- R2: Op codes are 0 add/sub, 1 convert, 2 multiply, 3 negated multiply, 4 multiply-accumulate, 5 abs/negate/register copy, 6 load from core or immediate, 7 copy to core, 8 divide, 9 square root and 10 compare. Every class occupies one issue cycle, except the following, which occupy two when `in_dbl` is 1: multiply, negated multiply and multiply-accumulate.
- R3: A single-precision divide holds the next issue for 10 cycles and a double-precision one for 20. A single-precision square root holds it for 13 cycles and a double-precision one for 28.
- R4: Results appear in these pipeline cycles: cycle 2 for classes 5 and 6; cycle 4 for add and convert; cycle 5 for multiplies in single precision and 6 in double; cycle 8 for multiply-accumulate in single precision and 9 in double; cycles 15/25 for divide; cycles 17/32 for square root (single/double). While `in_valid` is high, `res_cycle` equals the issue cycle count plus that value minus one, and `res_wr` is 1 only for classes that write a register.
- R5: Sources A and B are consumed in cycle 1. A consumer issuing k cycles after its producer waits until the producer's result cycle minus k is no greater than the consumer's need cycle.
- R6: Source C is the accumulator and is used only by multiply-accumulate. Without forwarding it is consumed in cycle 3.
- R7: A multiply-accumulate whose accumulator equals the destination of the last issued instruction, where that instruction is a multiply (class 2) or multiply-accumulate of the same precision, needs no wait on the accumulator. A mismatch in precision falls back to R6.
- R8: With `in_dbl` set, a register field value n selects the double register covering singles 2n and 2n+1, using only the low four field bits. A pending write to either half blocks a reader of the pair.
- R9: A convert reads its source in the opposite precision to its destination.
- R10: `stall_cnt` counts the cycles the current valid descriptor has been held. It reads 0 in the cycle the descriptor first appears and returns to 0 after issue.
- R11: Copy to core and compare write no register, so a later reader of their destination field issues without waiting for them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Descriptor present |
| in_op | input | 4 | Operation class code |
| in_dbl | input | 1 | 1 = double precision |
| in_dst | input | 5 | Destination register field |
| in_srca | input | 5 | Source A register field |
| in_srcb | input | 5 | Source B register field |
| in_srcc | input | 5 | Accumulator register field |
| in_ready | output | 1 | Descriptor may issue this cycle |
| stall_cnt | output | 8 | Cycles the current descriptor has waited |
| res_cycle | output | 16 | Cycle count in which the result appears |
| res_wr | output | 1 | Descriptor writes an FP register |

## Verification
Back-to-back independent pairs separate occupancy from dependency stalls. Long-latency producers followed by accumulator readers tell the cycle-3 accumulator need apart from the cycle-1 operand need. Multiply-to-accumulate chains in matching and mismatched precision expose whether the forwarding path is granted exactly when it should be. Mixed single and double accesses to overlapping registers, converts, and no-destination classes check the aliasing and the operand precision. Seeded random sequences over a small register window then mix all classes with idle gaps, and every issue cycle is compared with a cycle-accurate bench model.

// File: rtl/fpsb_pkg.sv
`timescale 1ns/1ps
package fpsb_pkg;

   // longest result cycle of any class
   localparam int MAX_LAT = 32;
   localparam int LAT_W   = $clog2(MAX_LAT + 1);

   // pipeline cycle in which operands are consumed
   localparam int NEED_OPND = 1;
   localparam int NEED_ACC  = 3;

   typedef enum logic [3:0] {
      OPC_ADD   = 4'd0,
      OPC_CVT   = 4'd1,
      OPC_MUL   = 4'd2,
      OPC_NMUL  = 4'd3,
      OPC_MAC   = 4'd4,
      OPC_UNARY = 4'd5,
      OPC_LDI   = 4'd6,
      OPC_XFER  = 4'd7,
      OPC_DIV   = 4'd8,
      OPC_SQRT  = 4'd9,
      OPC_CMP   = 4'd10
   } fp_op_e;

endpackage

// File: rtl/fpsb_timing.sv
`timescale 1ns/1ps
module fpsb_timing
   import fpsb_pkg::*;
(
   input  logic [3:0]       op,
   input  logic             dbl,
   output logic [LAT_W-1:0] occ,
   output logic [LAT_W-1:0] res,
   output logic             wr_dst,
   output logic [2:0]       use_src,
   output logic             src_dbl,
   output logic             mul_fam,
   output logic             is_mac
);

   always_comb begin
      occ     = LAT_W'(1);
      res     = LAT_W'(4);
      wr_dst  = 1'b1;
      use_src = 3'b011;
      src_dbl = dbl;
      mul_fam = 1'b0;
      is_mac  = 1'b0;
      case (op)
         OPC_ADD: ;
         OPC_CVT: begin
            use_src = 3'b001;
            src_dbl = ~dbl;
         end
         OPC_MUL: begin
            occ     = LAT_W'(dbl ? 2 : 1);
            res     = LAT_W'(dbl ? 6 : 5);
            mul_fam = 1'b1;
         end
         OPC_NMUL: begin
            occ = LAT_W'(dbl ? 2 : 1);
            res = LAT_W'(dbl ? 6 : 5);
         end
         OPC_MAC: begin
            occ     = LAT_W'(dbl ? 2 : 1);
            res     = LAT_W'(dbl ? 9 : 8);
            use_src = 3'b111;
            mul_fam = 1'b1;
            is_mac  = 1'b1;
         end
         OPC_UNARY: begin
            res     = LAT_W'(2);
            use_src = 3'b001;
         end
         OPC_LDI: begin
            res     = LAT_W'(2);
            use_src = 3'b000;
         end
         OPC_XFER: begin
            res     = LAT_W'(1);
            wr_dst  = 1'b0;
            use_src = 3'b001;
         end
         OPC_DIV: begin
            occ = LAT_W'(dbl ? 20 : 10);
            res = LAT_W'(dbl ? 25 : 15);
         end
         OPC_SQRT: begin
            occ     = LAT_W'(dbl ? 28 : 13);
            res     = LAT_W'(dbl ? 32 : 17);
            use_src = 3'b001;
         end
         OPC_CMP: begin
            wr_dst = 1'b0;
         end
         default: begin
            res     = LAT_W'(1);
            wr_dst  = 1'b0;
            use_src = 3'b000;
         end
      endcase
   end

endmodule

// File: rtl/fpsb_regtrack.sv
`timescale 1ns/1ps
module fpsb_regtrack
   import fpsb_pkg::*;
#(
   parameter int NREG = 32,
   parameter int NRD  = 3
)(
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  wr_en,
   input  logic [$clog2(NREG)-1:0]               wr_idx,
   input  logic                                  wr_dbl,
   input  logic [LAT_W-1:0]                      wr_val,
   input  logic [NRD-1:0][$clog2(NREG)-1:0]      rd_idx,
   input  logic [NRD-1:0]                        rd_dbl,
   output logic [NRD-1:0][LAT_W-1:0]             rd_cnt
);

   localparam int REG_W = $clog2(NREG);

   logic [LAT_W-1:0] cnt_q [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      localparam logic [REG_W-1:0] GI = REG_W'(g);
      logic hit;

      assign hit = wr_en && (wr_dbl ? (wr_idx[REG_W-2:0] == GI[REG_W-1:1])
                                    : (wr_idx == GI));

      always_ff @(posedge clk) begin
         if (!rst_n)                 cnt_q[g] <= '0;
         else if (hit)               cnt_q[g] <= wr_val;
         else if (cnt_q[g] != '0)    cnt_q[g] <= cnt_q[g] - 1'b1;
      end

      // R5: a pending result moves one cycle closer every clock
      a_r5_countdown: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt_q[g] != '0 && !hit) |=> (cnt_q[g] == $past(cnt_q[g]) - 1'b1));
   end

   for (genvar r = 0; r < NRD; r++) begin : g_rd
      logic [REG_W-1:0] lo, hi;
      assign lo = rd_dbl[r] ? {rd_idx[r][REG_W-2:0], 1'b0} : rd_idx[r];
      assign hi = rd_dbl[r] ? {rd_idx[r][REG_W-2:0], 1'b1} : rd_idx[r];
      assign rd_cnt[r] = (cnt_q[lo] > cnt_q[hi]) ? cnt_q[lo] : cnt_q[hi];
   end

endmodule

// File: rtl/fp_issue_sb.sv
`timescale 1ns/1ps
module fp_issue_sb
   import fpsb_pkg::*;
#(
   parameter int NREG    = 32,
   parameter int CYC_W   = 16,
   parameter int STALL_W = 8
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   input  logic [3:0]                in_op,
   input  logic                      in_dbl,
   input  logic [$clog2(NREG)-1:0]   in_dst,
   input  logic [$clog2(NREG)-1:0]   in_srca,
   input  logic [$clog2(NREG)-1:0]   in_srcb,
   input  logic [$clog2(NREG)-1:0]   in_srcc,
   output logic                      in_ready,
   output logic [STALL_W-1:0]        stall_cnt,
   output logic [CYC_W-1:0]          res_cycle,
   output logic                      res_wr
);

   localparam int REG_W = $clog2(NREG);
   localparam int NRD   = 3;
   localparam logic [NRD-1:0][LAT_W-1:0] NEED =
      {LAT_W'(NEED_ACC), LAT_W'(NEED_OPND), LAT_W'(NEED_OPND)};

   if (NREG < 4 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
      $error("fp_issue_sb: NREG must be a power of two, at least 4");
   end
   if (STALL_W < 2 || CYC_W < LAT_W + 1) begin : g_bad_width
      $error("fp_issue_sb: counter widths too small");
   end

   // class decode
   logic [LAT_W-1:0] t_occ, t_res;
   logic             t_wr, t_sdbl, t_mulfam, t_mac;
   logic [NRD-1:0]   t_use;

   fpsb_timing u_tim (
      .op      (in_op),
      .dbl     (in_dbl),
      .occ     (t_occ),
      .res     (t_res),
      .wr_dst  (t_wr),
      .use_src (t_use),
      .src_dbl (t_sdbl),
      .mul_fam (t_mulfam),
      .is_mac  (t_mac)
   );

   logic fire;

   // per-register pending-result tracking
   logic [NRD-1:0][REG_W-1:0] rd_idx;
   logic [NRD-1:0]            rd_dbl;
   logic [NRD-1:0][LAT_W-1:0] rd_cnt;

   assign rd_idx = {in_srcc, in_srcb, in_srca};
   assign rd_dbl = {in_dbl, t_sdbl, t_sdbl};

   fpsb_regtrack #(.NREG(NREG), .NRD(NRD)) u_trk (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (fire && t_wr),
      .wr_idx (in_dst),
      .wr_dbl (in_dbl),
      .wr_val (t_res - LAT_W'(1)),
      .rd_idx (rd_idx),
      .rd_dbl (rd_dbl),
      .rd_cnt (rd_cnt)
   );

   // accumulator forwarding from the last issued multiply family op
   logic             lst_mul_q, lst_dbl_q;
   logic [REG_W-1:0] lst_dst_q;
   logic             acc_same, fwd_ok;

   assign acc_same = in_dbl ? (in_srcc[REG_W-2:0] == lst_dst_q[REG_W-2:0])
                            : (in_srcc == lst_dst_q);
   assign fwd_ok   = t_mac && lst_mul_q && (lst_dbl_q == in_dbl) && acc_same;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lst_mul_q <= 1'b0;
         lst_dbl_q <= 1'b0;
         lst_dst_q <= '0;
      end else if (fire) begin
         lst_mul_q <= t_mulfam;
         lst_dbl_q <= in_dbl;
         lst_dst_q <= in_dst;
      end
   end

   // operand hazard per source role
   logic [NRD-1:0] exempt, haz;
   assign exempt = {fwd_ok, {(NRD-1){1'b0}}};

   for (genvar r = 0; r < NRD; r++) begin : g_haz
      assign haz[r] = t_use[r] && !exempt[r] && (rd_cnt[r] > NEED[r]);
   end

   // issue slot occupancy
   logic [LAT_W-1:0] busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n)              busy_q <= '0;
      else if (fire)           busy_q <= t_occ - LAT_W'(1);
      else if (busy_q != '0)   busy_q <= busy_q - 1'b1;
   end

   assign in_ready = (busy_q == '0) && !(|haz);
   assign fire     = in_valid && in_ready;

   // cycle and stall counters
   logic [CYC_W-1:0]   cyc_q;
   logic [STALL_W-1:0] stall_q;

   always_ff @(posedge clk) begin
      if (!rst_n) cyc_q <= '0;
      else        cyc_q <= cyc_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !in_valid || fire) stall_q <= '0;
      else if (stall_q != '1)          stall_q <= stall_q + 1'b1;
   end

   assign stall_cnt = stall_q;
   assign res_cycle = cyc_q + CYC_W'(t_res) - CYC_W'(1);
   assign res_wr    = t_wr;

   // R1: the block leaves reset idle with nothing pending
   a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (busy_q == '0 && stall_cnt == '0));

   // R3: a divide or square root never lets the next op issue one cycle later
   a_r3_long_block: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && (in_op == OPC_DIV || in_op == OPC_SQRT)) |=> !in_ready);

   // R10: a held descriptor's wait count climbs by one per cycle
   a_r10_stall_step: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_ready && stall_cnt != '1) |=>
         (stall_cnt == $past(stall_cnt) + 1'b1));

   // R2: a double multiply-accumulate keeps the slot for its second cycle
   a_r2_dbl_mac_occ: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && in_op == OPC_MAC && in_dbl) |=> !in_ready);

endmodule

// File: tb/sim_fp_issue_sb.sv
`timescale 1ns/1ps
module sim_fp_issue_sb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [3:0] in_op = '0;
   logic       in_dbl = 1'b0;
   logic [4:0] in_dst = '0, in_srca = '0, in_srcb = '0, in_srcc = '0;
   logic        in_ready;
   logic [7:0]  stall_cnt;
   logic [15:0] res_cycle;
   logic        res_wr;

   always #4 clk = ~clk;

   fp_issue_sb u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .in_dbl(in_dbl), .in_dst(in_dst), .in_srca(in_srca), .in_srcb(in_srcb),
      .in_srcc(in_srcc), .in_ready(in_ready), .stall_cnt(stall_cnt),
      .res_cycle(res_cycle), .res_wr(res_wr)
   );

   int bcyc;
   always @(posedge clk) begin
      if (!rst_n) bcyc <= 0;
      else        bcyc <= bcyc + 1;
   end

   int nchk = 0;
   int nerr = 0;

   task automatic chk(string tag, string what, int act, int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // timing model taken from the requirements
   function automatic int m_occ(int op, bit d);
      case (op)
         2, 3, 4: return d ? 2 : 1;
         8:       return d ? 20 : 10;
         9:       return d ? 28 : 13;
         default: return 1;
      endcase
   endfunction

   function automatic int m_res(int op, bit d);
      case (op)
         0, 1:    return 4;
         2, 3:    return d ? 6 : 5;
         4:       return d ? 9 : 8;
         5, 6:    return 2;
         8:       return d ? 25 : 15;
         9:       return d ? 32 : 17;
         default: return 0;
      endcase
   endfunction

   function automatic bit m_wr(int op);
      return (op <= 6) || op == 8 || op == 9;
   endfunction

   function automatic bit m_usea(int op);
      return op != 6;
   endfunction

   function automatic bit m_useb(int op);
      return op == 0 || op == 2 || op == 3 || op == 4 || op == 8 || op == 10;
   endfunction

   int  rdy [32];
   int  busy_until = 0;
   bit  lst_mul = 1'b0, lst_dbl = 1'b0;
   int  lst_dst = 0;

   function automatic int half_lo(int idx, bit d);
      return d ? (idx % 16) * 2 : idx;
   endfunction

   function automatic int rdy_of(int idx, bit d);
      int lo = half_lo(idx, d);
      int hi = d ? lo + 1 : lo;
      return (rdy[lo] > rdy[hi]) ? rdy[lo] : rdy[hi];
   endfunction

   function automatic int imax(int a, int b);
      return (a > b) ? a : b;
   endfunction

   task automatic run_op(string tag, int op, bit d, int dst, int a, int b, int c, int gap);
      int  t0, texp, tc, res, lo;
      bit  sd, fw;
      @(negedge clk);
      in_valid = 1'b0;
      repeat (gap) @(negedge clk);
      in_op = op[3:0]; in_dbl = d; in_dst = dst[4:0];
      in_srca = a[4:0]; in_srcb = b[4:0]; in_srcc = c[4:0];
      in_valid = 1'b1;
      t0 = bcyc;
      sd = (op == 1) ? !d : d;
      texp = imax(t0, busy_until);
      if (m_usea(op)) texp = imax(texp, rdy_of(a, sd) - 1);
      if (m_useb(op)) texp = imax(texp, rdy_of(b, sd) - 1);
      if (op == 4) begin
         fw = lst_mul && (lst_dbl == d) &&
              (d ? ((c % 16) == (lst_dst % 16)) : (c == lst_dst));
         if (!fw) texp = imax(texp, rdy_of(c, d) - 3);
      end
      #1;
      while (!in_ready) begin
         @(negedge clk);
         #1;
      end
      tc = bcyc;
      chk(tag, "issue cycle", tc, texp);
      chk("R10", "stall_cnt at issue", int'(stall_cnt), tc - t0);
      chk("R4", "res_wr", int'(res_wr), int'(m_wr(op)));
      res = m_res(op, d);
      if (m_wr(op)) chk("R4", "res_cycle", int'(res_cycle), (tc + res - 1) % 65536);
      busy_until = tc + m_occ(op, d);
      if (m_wr(op)) begin
         lo = half_lo(dst, d);
         rdy[lo] = tc + res;
         if (d) rdy[lo + 1] = tc + res;
      end
      lst_mul = (op == 2 || op == 4);
      lst_dbl = d;
      lst_dst = dst;
      @(posedge clk);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      nchk++;
      nerr++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      finish_run();
   end

   initial begin : main
      void'($urandom(32'd4242));
      foreach (rdy[i]) rdy[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk("R1", "in_ready after reset", int'(in_ready), 1);
      chk("R1", "stall_cnt after reset", int'(stall_cnt), 0);

      // R2: occupancy of single- and two-cycle classes
      run_op("R2", 0, 0, 1, 2, 3, 0, 2);
      run_op("R2", 0, 0, 4, 5, 6, 0, 0);
      run_op("R2", 2, 1, 5, 8, 9, 0, 40);
      run_op("R2", 0, 0, 20, 21, 22, 0, 0);
      // R3: long blocking classes
      run_op("R3", 8, 0, 1, 2, 3, 0, 40);
      run_op("R3", 0, 0, 4, 5, 6, 0, 0);
      run_op("R3", 9, 1, 1, 2, 3, 0, 40);
      run_op("R3", 0, 0, 4, 5, 6, 0, 0);
      // R5: plain read-after-write
      run_op("R5", 0, 0, 10, 2, 3, 0, 40);
      run_op("R5", 0, 0, 11, 10, 3, 0, 0);
      // R6: accumulator consumed in cycle 3
      run_op("R6", 8, 0, 12, 2, 3, 0, 40);
      run_op("R6", 4, 0, 13, 14, 15, 12, 0);
      // R7: forwarding into the accumulator
      run_op("R7", 2, 0, 1, 2, 3, 0, 40);
      run_op("R7", 4, 0, 1, 2, 3, 1, 0);
      run_op("R7", 4, 0, 1, 2, 3, 1, 0);
      run_op("R7", 2, 1, 2, 5, 6, 0, 40);
      run_op("R7", 4, 1, 2, 5, 6, 2, 0);
      run_op("R7", 2, 0, 4, 8, 9, 0, 40);
      run_op("R7", 4, 1, 2, 5, 6, 2, 0);
      // R8: double reads alias single writes
      run_op("R8", 0, 0, 5, 8, 9, 0, 40);
      run_op("R8", 5, 1, 9, 2, 0, 0, 0);
      // R9: convert reads the other precision
      run_op("R9", 0, 0, 5, 8, 9, 0, 40);
      run_op("R9", 1, 1, 3, 5, 0, 0, 0);
      run_op("R9", 0, 1, 3, 8, 9, 0, 40);
      run_op("R9", 1, 0, 20, 3, 0, 0, 0);
      // R11: no-destination classes leave the scoreboard alone
      run_op("R11", 10, 0, 8, 1, 2, 0, 40);
      run_op("R11", 0, 0, 12, 8, 8, 0, 0);
      run_op("R11", 7, 0, 9, 1, 0, 0, 40);
      run_op("R11", 0, 0, 13, 9, 9, 0, 0);

      // seeded random mix over a small register window
      for (int n = 0; n < 300; n++) begin
         int op  = $urandom_range(0, 10);
         bit d   = 1'($urandom_range(0, 1));
         int dst = $urandom_range(0, 7);
         int a   = $urandom_range(0, 7);
         int b   = $urandom_range(0, 7);
         int c   = $urandom_range(0, 7);
         int gap = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 3) : 0;
         if (op == 4 && $urandom_range(0, 1) == 1) c = lst_dst;
         run_op("R5", op, d, dst, a, b, c, gap);
      end

      @(negedge clk);
      in_valid = 1'b0;
      repeat (4) @(negedge clk);
      finish_run();
   end

endmodule